// File: doc/BRIEF.md
# Dual-Channel Shared-Timebase PWM Generator

This block produces two pulse-width-modulated digital outputs from one common timebase. A programmable prescaler divides the input clock, and its enable pulse advances a shared period counter. Each channel compares its own compare register against that counter and drives a registered single-bit output. Because both channels read the same counter, they always run at the same period and phase. The duty ratio is set in steps of one part in 255, from fully off to fully on.

A simple register port configures the block. A single-cycle write strobe carries an address and an 8-bit value that is loaded into the prescaler register or into one of the two compare registers. A combinational read port returns the stored values. A compare write reaches its output straight away. A prescaler write is picked up at the next prescaler reload.

Top module: `pwm_dual`

## Requirements
- R1: The period counter advances by one exactly once every (prescaler value + 1) input clock cycles. With a prescaler value of 0 it advances on every cycle.
- R2: Both channels use the same counter, so outputs with equal compare values are identical on every cycle.
- R3: The counter steps through 0 to 254 and then returns to 0. The output period is therefore 255 × (prescaler value + 1) clock cycles.
- R4: A channel output is 0 when its compare value is strictly greater than the counter and 1 otherwise. The output is registered, so it reflects the counter and compare values of the previous cycle. Over one period, a compare value of C gives 255 − C high cycles.
- R5: A compare value of 0x00 holds the output at 1 on every cycle. A compare value of 0xFF holds it at 0 on every cycle.
- R6: A compare write takes effect without waiting for the end of the period. If the strobe is sampled at clock edge k, the output reflects the new value at edge k+1.
- R7: A prescaler write does not cut short the countdown already in progress. The new value is loaded at the next reload, when the countdown reaches zero.
- R8: A synchronous active-high reset clears the prescaler register, the compare registers, the prescaler countdown and the counter to 0. Both outputs are 1 while reset is held.
- R9: Address 0 selects the prescaler, address 1 selects the channel 0 compare, and address 2 selects the channel 1 compare. A write to address 3 changes no register. The read port returns the stored value of the addressed register, and reads 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write value |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Stored value of the selected register |
| pwm_out | output | 2 | Channel outputs, bit n belongs to channel n |

## Verification
The bench builds the block with its default parameters: 8-bit data and two channels. This brings the real 255-count wrap and the 0xFF never-reached case into a short run. Prescaler values of 0, 2 and 4 keep each period between 255 and 1275 cycles. That makes it affordable to measure whole periods, count high cycles per window, and change the prescaler in the middle of a countdown while a reference model tracks every output cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_DATA_W = 8;
    localparam int PWM_NUM_CH = 2;

    // address 0 is the prescaler; compare registers follow from 1
    localparam int ADDR_PRESCALE  = 0;
    localparam int ADDR_CMP_FIRST = 1;

    // last counter value before wrap: one below the all-ones code
    function automatic int count_limit(input int width);
        return (1 << width) - 2;
    endfunction

    typedef enum logic [1:0] {
        TB_IDLE,
        TB_COUNTDOWN,
        TB_RELOAD
    } tb_phase_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int DATA_W = pwm_pkg::PWM_DATA_W,
    parameter int NUM_CH = pwm_pkg::PWM_NUM_CH,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             prescale,
    output logic [NUM_CH-1:0][DATA_W-1:0] cmp
);
    import pwm_pkg::*;

    localparam logic [ADDR_W-1:0] SEL_PRE = ADDR_W'(ADDR_PRESCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale <= '0;
        end else if (wr_en && wr_addr == SEL_PRE) begin
            prescale <= wr_data;
        end
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
            localparam logic [ADDR_W-1:0] SEL_CH = ADDR_W'(ADDR_CMP_FIRST + ch);
            always_ff @(posedge clk) begin
                if (rst) begin
                    cmp[ch] <= '0;
                end else if (wr_en && wr_addr == SEL_CH) begin
                    cmp[ch] <= wr_data;
                end
            end

            // R9: addressed compare register takes the written byte
            p_cmp_write_r9: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == SEL_CH) |=> (cmp[ch] == $past(wr_data)));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_addr == SEL_PRE) begin
            rd_data = prescale;
        end
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr == ADDR_W'(ADDR_CMP_FIRST + ch)) begin
                rd_data = cmp[ch];
            end
        end
    end

    // R9: the prescaler register only moves on its own address
    p_pre_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == SEL_PRE) |=> $stable(prescale));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DATA_W = pwm_pkg::PWM_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] prescale,
    output logic [DATA_W-1:0] count,
    output logic              tick
);
    import pwm_pkg::*;

    localparam logic [DATA_W-1:0] CNT_MAX = DATA_W'(count_limit(DATA_W));

    logic [DATA_W-1:0] div_q;
    tb_phase_e         phase;

    always_comb begin
        if (rst)             phase = TB_IDLE;
        else if (div_q == 0) phase = TB_RELOAD;
        else                 phase = TB_COUNTDOWN;
    end

    assign tick = (phase == TB_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            case (phase)
                TB_RELOAD:    div_q <= prescale;
                TB_COUNTDOWN: div_q <= div_q - 1'b1;
                default:      div_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= (count == CNT_MAX) ? '0 : count + 1'b1;
        end
    end

    // R3: counter never leaves 0..limit
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);

    // R1: counter moves only on an enable pulse
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3: an enable at the limit wraps to zero
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && count == CNT_MAX) |=> (count == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int DATA_W = pwm_pkg::PWM_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] cmp,
    output logic              pwm
);
    logic below;

    assign below = (cmp > count);

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b1;
        else     pwm <= ~below;
    end

    // R5: all-ones compare forces the output low
    p_const_low_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp == '1) |=> !pwm);

    // R5: zero compare forces the output high
    p_const_high_r5: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |=> pwm);
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual #(
    parameter int DATA_W = pwm_pkg::PWM_DATA_W,
    parameter int NUM_CH = pwm_pkg::PWM_NUM_CH,
    parameter int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [DATA_W-1:0]             prescale;
    logic [NUM_CH-1:0][DATA_W-1:0] cmp;
    logic [DATA_W-1:0]             count;
    logic                          tick;

    pwm_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .prescale (prescale),
        .cmp      (cmp)
    );

    pwm_timebase #(.DATA_W(DATA_W)) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .prescale (prescale),
        .count    (count),
        .tick     (tick)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            pwm_channel #(.DATA_W(DATA_W)) u_ch (
                .clk   (clk),
                .rst   (rst),
                .count (count),
                .cmp   (cmp[ch]),
                .pwm   (pwm_out[ch])
            );
        end
    endgenerate

    // R2: equal compare values give equal outputs
    p_shared_base_r2: assert property (@(posedge clk) disable iff (rst)
        (cmp[0] == cmp[NUM_CH-1]) |=> (pwm_out[0] == pwm_out[NUM_CH-1]));

    // R8: outputs come out of reset high
    p_reset_high_r8: assert property (@(posedge clk)
        rst |=> (pwm_out == '1));
endmodule

// File: tb/tb_pwm_dual.sv
`timescale 1ns/1ps
module tb_pwm_dual;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwm_dual dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model, built from the requirements ----------------
    logic [1:0] exp_q[$];
    int m_pre = 0, m_div = 0, m_cnt = 0;
    int m_cmp0 = 0, m_cmp1 = 0;

    always @(posedge clk) begin
        logic [1:0] e;
        e[0] = !(m_cmp0 > m_cnt);
        e[1] = !(m_cmp1 > m_cnt);
        if (rst) begin
            m_pre = 0; m_div = 0; m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0;
            e = 2'b11;
        end else begin
            if (m_div == 0) begin
                m_div = m_pre;
                m_cnt = (m_cnt == 254) ? 0 : m_cnt + 1;
            end else begin
                m_div = m_div - 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_pre  = int'(wr_data);
                    2'd1: m_cmp0 = int'(wr_data);
                    2'd2: m_cmp1 = int'(wr_data);
                    default: ;
                endcase
            end
        end
        exp_q.push_back(e);
    end

    // monitor: scoreboard compare every cycle (R4, also covers R1 R2 R3 R6 R7)
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0 && !done) begin
                logic [1:0] e;
                e = exp_q.pop_front();
                n_chk++;
                if (pwm_out !== e) begin
                    n_fail++;
                    $display("FAIL R4 scoreboard t=%0t actual=%b expected=%b", $time, pwm_out, e);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    // cycles between two rising edges of a channel output
    task automatic measure(input int ch, output int per);
        logic prev;
        int lim;
        per = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        lim = 0;
        while (!( !prev && pwm_out[ch] === 1'b1 ) && lim < 5000) begin
            prev = pwm_out[ch];
            @(negedge clk);
            lim++;
        end
        prev = pwm_out[ch];
        @(negedge clk);
        per = 1;
        while (!( !prev && pwm_out[ch] === 1'b1 ) && per < 5000) begin
            prev = pwm_out[ch];
            @(negedge clk);
            per++;
        end
    endtask

    task automatic count_high(input int ch, input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch] === 1'b1) highs++;
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, p, h;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 outputs in reset", int'(pwm_out), 3);
        for (int a = 0; a < 3; a++) begin
            read_reg(2'(a), v);
            check("R8 register cleared", v, 0);
        end
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 outputs after reset", int'(pwm_out), 3);

        // R9: address decode and readback
        write_reg(2'd0, 8'd0);
        write_reg(2'd1, 8'd10);
        write_reg(2'd2, 8'd200);
        read_reg(2'd1, v); check("R9 readback cmp0", v, 10);
        read_reg(2'd2, v); check("R9 readback cmp1", v, 200);
        read_reg(2'd0, v); check("R9 readback prescale", v, 0);
        write_reg(2'd3, 8'h5A);
        read_reg(2'd0, v); check("R9 addr3 ignored prescale", v, 0);
        read_reg(2'd1, v); check("R9 addr3 ignored cmp0", v, 10);
        read_reg(2'd2, v); check("R9 addr3 ignored cmp1", v, 200);
        read_reg(2'd3, v); check("R9 addr3 reads zero", v, 0);

        // R4: duty per period with prescale 0
        count_high(0, 255, h); check("R4 ch0 high cycles cmp=10", h, 245);
        count_high(1, 255, h); check("R4 ch1 high cycles cmp=200", h, 55);

        // R3 R1: period with prescale 0 and 2
        write_reg(2'd1, 8'd128);
        measure(0, p); check("R3 period prescale 0", p, 255);
        write_reg(2'd0, 8'd2);
        repeat (10) @(negedge clk);
        measure(0, p); check("R1 period prescale 2", p, 765);

        // R2: equal compares give identical outputs
        write_reg(2'd2, 8'd128);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm_out[0] !== pwm_out[1]) begin
                check("R2 channels identical", int'(pwm_out), 0);
                break;
            end
        end
        check("R2 channels identical end", int'(pwm_out[0]), int'(pwm_out[1]));

        // R5: constant levels
        write_reg(2'd0, 8'd0);
        write_reg(2'd1, 8'hFF);
        write_reg(2'd2, 8'h00);
        @(negedge clk);
        count_high(0, 300, h); check("R5 cmp 0xFF constant low", h, 0);
        count_high(1, 300, h); check("R5 cmp 0x00 constant high", h, 300);

        // R6: immediate compare update (strobe at edge k, output at k+1)
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 output before update edge", int'(pwm_out[0]), 0);
        @(negedge clk);
        check("R6 output one edge after write", int'(pwm_out[0]), 1);

        // R7: prescale change during a long countdown, then R1 period with 4
        write_reg(2'd1, 8'd100);
        write_reg(2'd0, 8'd40);
        repeat (5) @(negedge clk);
        write_reg(2'd0, 8'd4);   // R7: scoreboard checks reload timing
        repeat (60) @(negedge clk);
        measure(0, p); check("R7 R1 period after reload prescale 4", p, 1275);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule